// File: doc/BRIEF.md
# Cursor Palette and Pattern Host Port

This block gives a host processor byte-wide access to the two storage resources of a hardware cursor. The first is a three-entry colour table: slot 0 is the overscan colour, slot 1 the cursor background and slot 2 the cursor foreground, each with an 8-bit red, green and blue component. The second is a 1024-byte pattern store. Both are reached through one data register, and a mode bit in a control register chooses which one is the target.

The host selects one of four registers with a 2-bit select field and performs single-cycle write or read strobes. In colour mode each data access moves through red, green and blue, and the address moves on only after blue. In pattern mode the 10-bit index is built from a 2-bit page field, held in the control register, and the 8-bit address register. It advances by one on every data access, and a wrap of the low byte carries into the page. Data reads are served from a prefetch register that always holds the entry the pointer currently addresses. Reading the colour table or the pattern for display is not part of this block.

Top module: `cursor_port`

## Requirements
- R1: After reset the address reads 00h, the control register reads 00h (colour mode, page 0), the component counter is at red and all colour slots read 00h.
- R2: The control register (select 2) holds the mode in bit 0 (0 = colour table, 1 = pattern store) and the pattern page in bits 2:1. A write loads both fields and restarts the component counter at red. A read returns {5'b0, page, mode}.
- R3: Writing the write-address register (select 0) or the read-address register (select 3) loads the low 8 bits of the pointer. A read of either select returns those low 8 bits.
- R4: In colour mode, data writes (select 1) store red, then green, then blue of the slot given by the address (0 overscan, 1 background, 2 foreground). After blue, the address increments by one.
- R5: In colour mode, data reads return red, green and blue of the addressed slot in that order, then continue with the next slot. A read-address write makes the addressed entry available at once.
- R6: In colour mode, addresses above 2 leave all slots unchanged on write and read as 00h. The component counter and the address still advance.
- R7: In pattern mode, each data access reaches byte {page, address} and then increments the 10-bit index. A wrap of the low byte from FFh carries into the page.
- R8: In pattern mode, data reads return the bytes previously written, in ascending index order.
- R9: An address-register write in the middle of a colour triplet restarts the next access at red.
- R10: In colour mode, the low byte wraps from FFh to 00h without changing the page. In pattern mode, the index wraps from 3FFh to 000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 2 | Register select: 0 write address, 1 data, 2 control, 3 read address |
| wr_i | input | 1 | Write strobe for the selected register (wins over rd_i) |
| rd_i | input | 1 | Read strobe for the selected register (advances the pointer on data) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |

## Verification
On every cycle, the assertions check the pointer discipline: an address load puts the counter at red, the red-green-blue step in colour mode holds the address until blue and then increments only the low byte, every pattern-mode access increments the full index, the counter never takes its unused code, and reads from colour addresses above 2 return zero. Only the bench's scenarios can show that stored data comes back in the right order and place. This covers triplet contents per slot, the pattern bytes read back across the page carry and the full index wrap, ignored writes leaving the slots intact, and pattern traffic leaving the colour table untouched.

// File: rtl/cursor_port_pkg.sv
package cursor_port_pkg;
  typedef enum logic [1:0] {
    C_RED = 2'd0,
    C_GRN = 2'd1,
    C_BLU = 2'd2
  } comp_e;

  typedef enum logic [1:0] {
    SEL_WADDR = 2'd0,
    SEL_DATA  = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_RADDR = 2'd3
  } sel_e;
endpackage

// File: rtl/cursor_ptr.sv
module cursor_ptr
  import cursor_port_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_addr_i,
  input  logic             ld_ctrl_i,
  input  logic             step_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [IDX_W-1:0] idx_o,
  output comp_e            comp_o,
  output logic             mode_o,
  output logic [IDX_W-1:0] idx_n_o,
  output comp_e            comp_n_o,
  output logic             mode_n_o
);
  localparam int PAGE_W = IDX_W - DW;
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);
  localparam logic [DW-1:0]    LOW_ONE = DW'(1);

  logic [IDX_W-1:0] idx_q, idx_n;
  comp_e            comp_q, comp_n;
  logic             mode_q, mode_n;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DW-1:PAGE_W+1];

  always_comb begin
    idx_n  = idx_q;
    comp_n = comp_q;
    mode_n = mode_q;
    if (ld_ctrl_i) begin
      mode_n                   = wdata_i[0];
      idx_n[IDX_W-1:DW]        = wdata_i[PAGE_W:1];
      comp_n                   = C_RED;
    end else if (ld_addr_i) begin
      idx_n[DW-1:0]            = wdata_i;
      comp_n                   = C_RED;
    end else if (step_i) begin
      if (mode_q) begin
        idx_n = idx_q + IDX_ONE;         // full index, page carries
      end else if (comp_q == C_BLU) begin
        comp_n        = C_RED;
        idx_n[DW-1:0] = idx_q[DW-1:0] + LOW_ONE;  // low byte only
      end else begin
        comp_n = comp_e'(comp_q + 2'd1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      comp_q <= C_RED;
      mode_q <= 1'b0;
    end else begin
      idx_q  <= idx_n;
      comp_q <= comp_n;
      mode_q <= mode_n;
    end
  end

  assign idx_o    = idx_q;
  assign comp_o   = comp_q;
  assign mode_o   = mode_q;
  assign idx_n_o  = idx_n;
  assign comp_n_o = comp_n;
  assign mode_n_o = mode_n;
endmodule

// File: rtl/cursor_palette.sv
module cursor_palette
  import cursor_port_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 8,
  parameter int PAL_N = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wentry_i,
  input  comp_e         wcomp_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] rentry_i,
  input  comp_e         rcomp_i,
  output logic [DW-1:0] rdata_o
);
  localparam int EW = (PAL_N > 1) ? $clog2(PAL_N) : 1;

  logic [PAL_N-1:0][2:0][DW-1:0] slots;

  for (genvar e = 0; e < PAL_N; e++) begin : g_slot
    logic [2:0][DW-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q <= '0;
      end else if (we_i && wentry_i == AW'(e)) begin
        slot_q[wcomp_i] <= wdata_i;
      end
    end
    assign slots[e] = slot_q;
  end

  always_comb begin
    if (rentry_i < AW'(PAL_N)) rdata_o = slots[rentry_i[EW-1:0]][rcomp_i];
    else                       rdata_o = '0;
  end
endmodule

// File: rtl/cursor_pattern_ram.sv
module cursor_pattern_ram #(
  parameter int DW = 8,
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/cursor_port.sv
module cursor_port
  import cursor_port_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IDX_W = 10,
  parameter int PAL_N = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    sel_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int PAGE_W = IDX_W - DW;

  logic             sel_data, acc;
  logic             ld_addr, ld_ctrl, pal_we, pat_we;
  logic [IDX_W-1:0] idx, idx_n;
  comp_e            comp, comp_n;
  logic             mode, mode_n;
  logic [DW-1:0]    pal_rd, pat_rd, rd_buf_q;

  assign sel_data = sel_i == SEL_DATA;
  assign acc      = (wr_i | rd_i) & sel_data;
  assign ld_addr  = wr_i & (sel_i == SEL_WADDR | sel_i == SEL_RADDR);
  assign ld_ctrl  = wr_i & (sel_i == SEL_CTRL);
  assign pal_we   = wr_i & sel_data & ~mode;
  assign pat_we   = wr_i & sel_data & mode;

  cursor_ptr #(.DW(DW), .IDX_W(IDX_W)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_addr_i(ld_addr),
    .ld_ctrl_i(ld_ctrl),
    .step_i   (acc),
    .wdata_i  (wdata_i),
    .idx_o    (idx),
    .comp_o   (comp),
    .mode_o   (mode),
    .idx_n_o  (idx_n),
    .comp_n_o (comp_n),
    .mode_n_o (mode_n)
  );

  cursor_palette #(.DW(DW), .AW(DW), .PAL_N(PAL_N)) u_pal (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pal_we),
    .wentry_i(idx[DW-1:0]),
    .wcomp_i (comp),
    .wdata_i (wdata_i),
    .rentry_i(idx_n[DW-1:0]),
    .rcomp_i (comp_n),
    .rdata_o (pal_rd)
  );

  cursor_pattern_ram #(.DW(DW), .AW(IDX_W)) u_pat (
    .clk_i  (clk_i),
    .we_i   (pat_we),
    .waddr_i(idx),
    .wdata_i(wdata_i),
    .raddr_i(idx_n),
    .rdata_o(pat_rd)
  );

  // prefetch: always holds the entry the next-cycle pointer addresses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_buf_q <= '0;
    else         rd_buf_q <= mode_n ? pat_rd : pal_rd;
  end

  always_comb begin
    unique case (sel_e'(sel_i))
      SEL_DATA: rdata_o = rd_buf_q;
      SEL_CTRL: rdata_o = DW'({idx[IDX_W-1:IDX_W-PAGE_W], mode});
      default:  rdata_o = idx[DW-1:0];
    endcase
  end
endmodule

// File: rtl/cursor_port_chk.sv
module cursor_port_chk
  import cursor_port_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IDX_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       sel_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW-1:0]    rdata_o,
  input logic [IDX_W-1:0] idx,
  input logic [1:0]       comp,
  input logic             mode
);
  logic acc;
  assign acc = (wr_i | rd_i) && sel_i == SEL_DATA;

  p_addr_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && (sel_i == SEL_WADDR || sel_i == SEL_RADDR)
    |=> idx[DW-1:0] == $past(wdata_i) && comp == 2'(C_RED));

  p_restart_red_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && sel_i != SEL_DATA |=> comp == 2'(C_RED));

  p_pal_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode && acc && comp != 2'(C_BLU)
    |=> idx == $past(idx) && comp == $past(comp) + 2'd1);

  p_pal_adv_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode && acc && comp == 2'(C_BLU)
    |=> comp == 2'(C_RED) && idx[DW-1:0] == $past(idx[DW-1:0]) + DW'(1)
        && idx[IDX_W-1:DW] == $past(idx[IDX_W-1:DW]));

  p_pat_inc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode && acc |=> idx == $past(idx) + IDX_W'(1));

  p_hole_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode && sel_i == SEL_DATA && idx[DW-1:0] > DW'(2) |-> rdata_o == '0);

  p_comp_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp != 2'd3);
endmodule

bind cursor_port cursor_port_chk #(.DW(DW), .IDX_W(IDX_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sel_i  (sel_i),
  .wr_i   (wr_i),
  .rd_i   (rd_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .idx    (idx),
  .comp   (comp),
  .mode   (mode)
);

// File: tb/sim_cursor_port.sv
module sim_cursor_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  cursor_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic op_wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); sel = s; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic op_rd(input logic [1:0] s, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); sel = s; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  // monitor: compares each read strobe against the scoreboard
  always begin
    @(negedge clk); #1;
    if (rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: got %02h expected none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s: got %02h expected %02h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    op_rd(0, 8'h00, "R1 address");
    op_rd(2, 8'h00, "R1 control");
    op_rd(3, 8'h00, "R1 read address");
    op_rd(1, 8'h00, "R1 slot0 red");
    // R4 triplet writes into slots 0..2
    op_wr(0, 8'h00);
    op_wr(1, 8'h11); op_wr(1, 8'h12); op_wr(1, 8'h13);
    op_wr(1, 8'h21); op_wr(1, 8'h22); op_wr(1, 8'h23);
    op_wr(1, 8'h31); op_wr(1, 8'h32); op_wr(1, 8'h33);
    op_rd(0, 8'h03, "R4 address after three triplets");
    // R5 read from background slot, flow into foreground
    op_wr(3, 8'h01);
    op_rd(3, 8'h01, "R3 read address readback");
    op_rd(1, 8'h21, "R5 bg red");
    op_rd(1, 8'h22, "R5 bg green");
    op_rd(1, 8'h23, "R5 bg blue");
    op_rd(1, 8'h31, "R5 fg red");
    op_rd(0, 8'h02, "R5 address after one step");
    // R9 restart mid-triplet
    op_wr(3, 8'h02);
    op_rd(1, 8'h31, "R9 fg red first");
    op_wr(3, 8'h02);
    op_rd(1, 8'h31, "R9 fg red again");
    op_wr(0, 8'h00); op_wr(1, 8'hAA);
    op_wr(0, 8'h00); op_wr(1, 8'hBB);
    op_wr(3, 8'h00);
    op_rd(1, 8'hBB, "R9 overwritten red");
    op_rd(1, 8'h12, "R9 green untouched");
    // R6 hole addresses
    op_wr(0, 8'h05);
    op_wr(1, 8'h77); op_wr(1, 8'h77); op_wr(1, 8'h77);
    op_rd(0, 8'h06, "R6 address still advances");
    op_wr(3, 8'h05);
    op_rd(1, 8'h00, "R6 hole red");
    op_rd(1, 8'h00, "R6 hole green");
    op_rd(1, 8'h00, "R6 hole blue");
    op_wr(3, 8'h02);
    op_rd(1, 8'h31, "R6 fg intact");
    // R10 colour-mode low byte wrap keeps page
    op_wr(2, 8'h06);
    op_rd(2, 8'h06, "R2 page 3 colour mode");
    op_wr(0, 8'hFF);
    op_wr(1, 8'h55); op_wr(1, 8'h55); op_wr(1, 8'h55);
    op_rd(0, 8'h00, "R10 low byte wrapped");
    op_rd(2, 8'h06, "R10 page unchanged");
    // R7/R8 pattern mode
    op_wr(2, 8'h01);
    op_rd(2, 8'h01, "R2 pattern mode page 0");
    op_wr(0, 8'h00);
    op_wr(1, 8'hA0); op_wr(1, 8'hA1); op_wr(1, 8'hA2); op_wr(1, 8'hA3);
    op_rd(0, 8'h04, "R7 per-byte increment");
    op_wr(3, 8'h00);
    op_rd(1, 8'hA0, "R8 byte 0");
    op_rd(1, 8'hA1, "R8 byte 1");
    op_rd(1, 8'hA2, "R8 byte 2");
    op_rd(1, 8'hA3, "R8 byte 3");
    // R7 carry into page
    op_wr(2, 8'h03);
    op_wr(0, 8'hFE);
    op_wr(1, 8'hC0); op_wr(1, 8'hC1); op_wr(1, 8'hC2);
    op_rd(2, 8'h05, "R7 page carried to 2");
    op_rd(0, 8'h01, "R7 low byte after carry");
    op_wr(2, 8'h03);
    op_wr(3, 8'hFE);
    op_rd(1, 8'hC0, "R7 byte 1FE");
    op_rd(1, 8'hC1, "R7 byte 1FF");
    op_rd(1, 8'hC2, "R7 byte 200 across carry");
    op_wr(2, 8'h01);
    op_wr(3, 8'h00);
    op_rd(1, 8'hA0, "R8 page 0 intact");
    // R10 full index wrap
    op_wr(2, 8'h07);
    op_wr(0, 8'hFF);
    op_wr(1, 8'hD0);
    op_rd(2, 8'h01, "R10 page wrapped to 0");
    op_rd(0, 8'h00, "R10 index wrapped");
    op_wr(1, 8'hD1);
    op_wr(3, 8'h00);
    op_rd(1, 8'hD1, "R10 write after wrap at 000");
    op_wr(2, 8'h07);
    op_wr(3, 8'hFF);
    op_rd(1, 8'hD0, "R10 byte 3FF");
    // colour table untouched by pattern traffic
    op_wr(2, 8'h00);
    op_wr(3, 8'h01);
    op_rd(1, 8'h21, "R4 bg red kept");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule